// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is a 32-bit arithmetic and logic unit, with a small register that holds four condition flags: negative, zero, carry and overflow. A 4-bit opcode selects one of nine operations: add, subtract, AND, OR, XOR, move, logical shift left, logical shift right and rotate right. The operations run on two operand words and a shift amount. The result is produced combinationally in the same cycle.

Each flag has its own update rule, so an operation may leave some flags at their previous values. The unchanged values come from the flag register, which feeds back into the datapath. The register takes the newly computed flags on a rising clock edge only while the set-flags input is high. This lets a sequence of operations choose which of them record their condition codes.

Top module: `alu_flagged_unit`

## Requirements
- R1: Opcode 0 (add) gives `a + b` and opcode 1 (subtract) gives `a - b`, both modulo 2^32.
- R2: Opcode 2 gives `a & b`, opcode 3 gives `a | b`, opcode 4 gives `a ^ b` and opcode 5 (move) gives `b`.
- R3: Opcode 6 shifts `a` left logically by `shamt`. Opcode 7 shifts it right logically by `shamt`. Opcode 8 rotates it right by `shamt`. A shift amount of 0 returns `a` unchanged.
- R4: For opcodes 0 to 8, negative (flags bit 3) takes bit 31 of the result. Zero (flags bit 2) is 1 exactly when all result bits are 0.
- R5: For add, carry (flags bit 1) is the carry out of bit 31. Overflow (flags bit 0) is 1 when both operands have the same sign and the result has the other sign.
- R6: For subtract, carry is 1 when no borrow occurs (unsigned `a >= b`) and 0 on a borrow. Overflow is computed as for adding `a` to the two's complement of `b`.
- R7: Opcodes 2 to 8 leave overflow unchanged. Opcodes 2 to 5 also leave carry unchanged.
- R8: For opcodes 6 to 8 with a nonzero `shamt`, carry takes the last bit shifted out of `a`. With `shamt` equal to 0, carry is left unchanged.
- R9: Opcodes 9 to 15 give a result of 0 and leave all four flags unchanged.
- R10: The flag register is cleared by an active-low asynchronous reset. On a rising edge it loads the computed flags only while `set_flags_i` is high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand, also the shift source |
| b_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift or rotate amount |
| set_flags_i | input | 1 | Load computed flags at the next rising edge |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The hardest cases to reach are the ones where a flag must keep an earlier value: a shift by zero keeping a set carry, or a logic operation keeping a set overflow. Random operands seldom produce these on their own. Directed steps therefore first set carry and overflow with chosen additions, then issue a zero-amount shift or a logic operation and look at the flags. The random phase also mixes zero shift amounts and set-flags low cycles at a raised rate, so that held flag values keep being compared against a bench model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_ORR = 4'd3,
        OP_EOR = 4'd4,
        OP_MOV = 4'd5,
        OP_LSL = 4'd6,
        OP_LSR = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_defined(input logic [3:0] op);
        return op <= 4'd8;
    endfunction

    function automatic logic op_is_bitwise(input logic [3:0] op);
        return (op >= 4'd2) && (op <= 4'd5);
    endfunction

    function automatic logic op_is_shift(input logic [3:0] op);
        return (op >= 4'd6) && (op <= 4'd8);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] xor_r
);
    always_comb begin
        and_r = a & b;
        or_r  = a | b;
        xor_r = a ^ b;
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   lsl_r,
    output logic [W-1:0]   lsr_r,
    output logic [W-1:0]   ror_r,
    output logic           lsl_c,
    output logic           lsr_c
);
    logic [W-1:0] lsl_st [SHW+1];
    logic [W-1:0] lsr_st [SHW+1];
    logic [W-1:0] ror_st [SHW+1];

    assign lsl_st[0] = a;
    assign lsr_st[0] = a;
    assign ror_st[0] = a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign lsl_st[k+1] = shamt[k] ? (lsl_st[k] << STEP) : lsl_st[k];
        assign lsr_st[k+1] = shamt[k] ? (lsr_st[k] >> STEP) : lsr_st[k];
        assign ror_st[k+1] = shamt[k] ? ((ror_st[k] >> STEP) | (ror_st[k] << (W - STEP)))
                                      : ror_st[k];
    end

    logic [W-1:0]   pre_l;
    logic [W-1:0]   pre_r;
    logic [SHW-1:0] amt_m1;

    always_comb begin
        amt_m1 = shamt - 1'b1;
        pre_l  = a << amt_m1;
        pre_r  = a >> amt_m1;
        lsl_c  = pre_l[W-1];
        lsr_c  = pre_r[0];
        lsl_r  = lsl_st[SHW];
        lsr_r  = lsr_st[SHW];
        ror_r  = ror_st[SHW];
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [3:0]     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] shamt,
    input  alu_flags_t     flags_in,
    output logic [W-1:0]   result,
    output alu_flags_t     flags_out
);
    logic [W-1:0] sum;
    logic         cout;
    logic         ovf;
    logic [W-1:0] and_r, or_r, xor_r;
    logic [W-1:0] lsl_r, lsr_r, ror_r;
    logic         lsl_c, lsr_c;
    logic         do_sub;

    assign do_sub = (op == OP_SUB);

    alu_addsub #(.W(W)) u_addsub (
        .a    (a),
        .b    (b),
        .sub  (do_sub),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a     (a),
        .b     (b),
        .and_r (and_r),
        .or_r  (or_r),
        .xor_r (xor_r)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shifter (
        .a     (a),
        .shamt (shamt),
        .lsl_r (lsl_r),
        .lsr_r (lsr_r),
        .ror_r (ror_r),
        .lsl_c (lsl_c),
        .lsr_c (lsr_c)
    );

    always_comb begin
        logic nz_shift;
        nz_shift  = (shamt != '0);
        flags_out = flags_in;
        result    = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                result      = sum;
                flags_out.c = cout;
                flags_out.v = ovf;
            end
            OP_AND: result = and_r;
            OP_ORR: result = or_r;
            OP_EOR: result = xor_r;
            OP_MOV: result = b;
            OP_LSL: begin
                result = lsl_r;
                if (nz_shift) flags_out.c = lsl_c;
            end
            OP_LSR: begin
                result = lsr_r;
                if (nz_shift) flags_out.c = lsr_c;
            end
            OP_ROR: begin
                result = ror_r;
                if (nz_shift) flags_out.c = ror_r[W-1];
            end
            default: result = '0;
        endcase
        if (op_defined(op)) begin
            flags_out.n = result[W-1];
            flags_out.z = (result == '0);
        end
    end

endmodule

// File: rtl/alu_flagged_unit.sv
module alu_flagged_unit
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           set_flags_i,
    output logic [W-1:0]   result_o,
    output logic [3:0]     flags_o
);
    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    state_t     state_d, state_q;
    alu_flags_t flags_new;

    alu_core #(.W(W), .SHW(SHW)) u_core (
        .op        (op_i),
        .a         (a_i),
        .b         (b_i),
        .shamt     (shamt_i),
        .flags_in  (state_q.flags),
        .result    (result_o),
        .flags_out (flags_new)
    );

    always_comb begin
        state_d = state_q;
        if (set_flags_i) state_d.flags = flags_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags_o = state_q.flags;

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i && op_defined(op_i) |=> flags_o[3] == $past(result_o[W-1])); // R4

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i && op_defined(op_i) |=> flags_o[2] == ($past(result_o) == '0)); // R4

    AST_KEEP_V: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i && (op_is_bitwise(op_i) || op_is_shift(op_i)) |=> $stable(flags_o[0])); // R7

    AST_BITWISE_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i && op_is_bitwise(op_i) |=> $stable(flags_o[1])); // R7

    AST_SHIFT0_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i && op_is_shift(op_i) && (shamt_i == '0) |=> $stable(flags_o[1])); // R8

    AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !op_defined(op_i) |-> result_o == '0); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o)); // R10

endmodule

// File: tb/alu_flagged_unit_tb.sv
module alu_flagged_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  shamt_i = '0;
    logic        set_flags_i = 1'b0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] mflags = 4'h0;

    always #10 clk = ~clk;

    alu_flagged_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .shamt_i(shamt_i), .set_flags_i(set_flags_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input int s,
                                          input logic [3:0] f);
        logic [31:0] r;
        logic [32:0] t;
        logic n, z, c, v;
        {n, z, c, v} = f;
        r = '0;
        case (op)
            4'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32];
                        v = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1: begin r = a - b; c = (a >= b);
                        v = (a[31] != b[31]) && (r[31] != a[31]); end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = b;
            4'd6: begin r = a << s; if (s != 0) c = a[32 - s]; end
            4'd7: begin r = a >> s; if (s != 0) c = a[s - 1]; end
            4'd8: begin r = (s == 0) ? a : ((a >> s) | (a << (32 - s)));
                        if (s != 0) c = r[31]; end
            default: return {32'h0, f};
        endcase
        n = r[31];
        z = (r == 0);
        return {r, n, z, c, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1/R5";
            4'd1: return "R1/R6";
            4'd2, 4'd3, 4'd4, 4'd5: return "R2/R7";
            4'd6, 4'd7, 4'd8: return "R3/R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int s, input logic sf);
        logic [35:0] e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; shamt_i = s[4:0]; set_flags_i = sf;
        #2;
        e = model(op, a, b, s, mflags);
        check(tag_of(op), result_o, e[35:4]);
        @(posedge clk);
        #1;
        if (sf) mflags = e[3:0];
        check(sf ? {tag_of(op), " R4 R10"} : "R10 hold", {28'h0, flags_o}, {28'h0, mflags});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #25;
        check("R10 reset", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases
        apply(4'd0, 32'h7FFF_FFFF, 32'h1, 0, 1);        // R5 overflow: V=1 N=1
        apply(4'd0, 32'hFFFF_FFFF, 32'h1, 0, 1);        // R5 carry: C=1 Z=1
        apply(4'd2, 32'hF0F0_0000, 32'h0F0F_0000, 0, 1); // R7 keep C
        apply(4'd0, 32'h8000_0000, 32'h8000_0000, 0, 1); // R5 C=1 V=1
        apply(4'd6, 32'h1234_5678, 32'h0, 0, 1);        // R8 shift by 0 keeps C
        apply(4'd5, 32'h0, 32'h8000_0001, 0, 1);        // R7 move keeps C,V
        apply(4'd7, 32'h0000_0002, 32'h0, 1, 1);        // R8 LSR carry 0, V kept
        apply(4'd6, 32'h8000_0000, 32'h0, 1, 1);        // R8 LSL out bit 1, Z=1
        apply(4'd8, 32'h0000_0001, 32'h0, 1, 1);        // R3 ROR wrap, C=1
        apply(4'd1, 32'h5, 32'h5, 0, 1);                // R6 equal: C=1 Z=1
        apply(4'd1, 32'h0, 32'h1, 0, 1);                // R6 borrow: C=0 N=1
        apply(4'd1, 32'h8000_0000, 32'h1, 0, 1);        // R6 overflow
        apply(4'd4, 32'hAAAA_AAAA, 32'h5555_5555, 0, 1); // R2 xor
        apply(4'd3, 32'h0, 32'h0, 0, 1);                // R2 or gives zero
        apply(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 1); // R9 undefined op
        apply(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0); // R10 no load
        apply(4'd7, 32'h8000_0000, 32'h0, 31, 1);       // R3 R8 max shift

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            int s;
            logic sf;
            op = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 9);
            s  = ($urandom % 4 == 0) ? 0 : int'($urandom % 32);
            sf = ($urandom % 5 != 0);
            apply(op, $urandom, ($urandom % 6 == 0) ? 32'h8000_0000 : $urandom, s, sf);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule